// File: doc/BRIEF.md
# Write-Back Write-Allocate Unified Second-Level Cache

This block is a unified second-level cache. It sits between two first-level caches and main memory. The instruction-side requester only reads. The data-side requester reads blocks and writes single words. A read returns one upstream block, which is the aligned slice of the cache line that holds the requested word. The cache is set-associative and replaces the least-recently-used way of a set. Each line has its own dirty bit.

Writes follow a write-back policy. A write that hits changes the line and marks it dirty, and memory is not touched. A write that misses first fetches the whole line from memory, then merges the word into it and marks the line dirty. If the way chosen for a fill holds a dirty line, that line goes out to memory before the fill read is issued.

The cache keeps four running totals. These are accesses, misses, misses whose victim was dirty, and the cycles the processor stalls on reads. A read stall costs a fixed lookup time plus a per-word transfer time for each word delivered upstream. Writes are assumed to be fully buffered and cost no stall. A combinational probe port reports, for any address, whether its line is present, where it is, whether it is dirty, and the line contents.

Top module: `wbl2_cache`

## Requirements
- R1: After reset all four counters read zero, neither acknowledge is asserted, neither memory request is asserted, and a probe of any address reports a miss.
- R2: A read that hits returns words w..w+UP_WORDS-1 of the line without any memory traffic. Here w is the word offset with its low log2(UP_WORDS) bits cleared. Word k of the upstream block is at bits [32k+31:32k] of `up_rdata`.
- R3: A write that hits replaces the addressed word, marks the line dirty and produces no memory traffic.
- R4: A write that misses reads the line from memory once. It then merges the written word into the line and leaves the line dirty.
- R5: A read that misses reads the line from memory exactly once, installs it clean and returns the requested block. The line address is the word address shifted right by log2(LINE_WORDS).
- R6: A fill goes to the lowest-numbered invalid way of the set. When every way of the set is valid, the fill goes to the least recently accessed way.
- R7: If the chosen victim is dirty, its line address and full contents are written to memory. The write must be acknowledged before the fill read is requested.
- R8: The access count rises by one per accepted request. The miss count rises by one per miss. The dirty-replacement count rises by one per miss whose victim was dirty.
- R9: Every read adds LOOKUP_CYC + XFER_CYC*UP_WORDS to the stall count. A write adds nothing.
- R10: When both requesters assert in the same cycle, the data side is acknowledged first. The instruction request stays pending and is served next.
- R11: The probe port reports hit, set index, way, dirty state and line words for any address, and leaves every counter and line unchanged.
- R12: Only one memory request is asserted at a time. A request and its address stay unchanged until memory answers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_req | input | 1 | Instruction-side read request, held until acknowledged |
| i_addr | input | ADDR_W | Instruction-side word address |
| i_ack | output | 1 | One-cycle completion of an instruction request |
| d_req | input | 1 | Data-side request, held until acknowledged |
| d_we | input | 1 | Data-side write select (1 = write one word) |
| d_addr | input | ADDR_W | Data-side word address |
| d_wdata | input | WORD_W | Data-side write word |
| d_ack | output | 1 | One-cycle completion of a data request |
| up_rdata | output | UP_WORDS*WORD_W | Upstream block, valid with the acknowledge of a read |
| mem_rd_req | output | 1 | Line read request to memory |
| mem_rd_addr | output | ADDR_W-log2(LINE_WORDS) | Line address to read |
| mem_rd_valid | input | 1 | Memory read data valid (ends the read) |
| mem_rd_data | input | LINE_WORDS*WORD_W | Line read from memory |
| mem_wr_req | output | 1 | Line write-back request to memory |
| mem_wr_addr | output | ADDR_W-log2(LINE_WORDS) | Line address to write |
| mem_wr_data | output | LINE_WORDS*WORD_W | Line contents to write |
| mem_wr_ack | input | 1 | Memory accepted the write |
| prb_addr | input | ADDR_W | Probe word address |
| prb_hit | output | 1 | Probed line present |
| prb_set | output | log2(SETS) | Set index of the probed address |
| prb_way | output | log2(WAYS) | Way holding the probed line |
| prb_dirty | output | 1 | Probed line is dirty |
| prb_line | output | LINE_WORDS*WORD_W | Probed line words (zero on miss) |
| cnt_access | output | CNT_W | Accepted requests |
| cnt_miss | output | CNT_W | Misses |
| cnt_dirty_repl | output | CNT_W | Misses whose victim was dirty |
| cnt_stall | output | CNT_W | Accumulated read stall cycles |

## Verification
The hardest case to reach is a dirty replacement. It needs a set whose ways are all valid, a dirty least-recently-used way, and then a miss on a new tag in that same set. The directed part of the bench builds this on purpose: a read miss, then a write hit, then a write miss into the second way, then a read of a third tag in that set. The random phase draws addresses from a small window so that conflicts in each set recur often. The arbitration corner is reached by raising both requests on the same edge, and the response order and data are then checked.

// File: rtl/l2c_pkg.sv
// Shared types for the second-level cache.
package l2c_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WB,
        ST_FILL,
        ST_DONE
    } l2c_state_e;
endpackage

// File: rtl/l2c_arb.sv
// Fixed-priority grant between the two requesters.
// Assumes the requests are held until acknowledged. A grant is only given
// while the controller is idle, and the data side always wins a tie.
module l2c_arb (
    input  logic i_req,
    input  logic d_req,
    input  logic idle,
    output logic gnt_i,
    output logic gnt_d
);
    // grant decode, data side first
    always_comb begin
        gnt_d = idle & d_req;
        gnt_i = idle & i_req & ~d_req;
    end
endmodule

// File: rtl/l2c_lru.sv
// Per-set recency ages for true LRU replacement.
// Each set holds a permutation of ages 0..WAYS-1, where 0 is the most recent.
// A touch makes the touched way age 0 and ages every way that was younger.
module l2c_lru #(
    parameter int SETS = 4,
    parameter int WAYS = 2,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [IDX_W-1:0] qry_set,
    output logic [WAY_W-1:0] lru_way
);
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAYS-1:0]  oldest_vec;

    // age update on every access that resolves to a way
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[touch_set][w] <= '0;
                else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
            end
        end
    end

    // pick the way carrying the oldest age in the queried set
    always_comb begin
        lru_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            oldest_vec[w] = (age_q[qry_set][w] == WAY_W'(WAYS - 1));
            if (oldest_vec[w]) lru_way = WAY_W'(w);
        end
    end

    // R6: the ages of a set stay a permutation, so exactly one way is oldest
    p_lru_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oldest_vec));
endmodule

// File: rtl/l2c_stats.sv
// Event counters for accesses, misses, dirty replacements and read stalls.
// Each event input is a single-cycle strobe. A read adds the fixed stall cost
// when it is accepted.
module l2c_stats #(
    parameter int CNT_W    = 32,
    parameter int STALL_RD = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_access,
    input  logic             ev_read,
    input  logic             ev_miss,
    input  logic             ev_dirty,
    output logic [CNT_W-1:0] cnt_access,
    output logic [CNT_W-1:0] cnt_miss,
    output logic [CNT_W-1:0] cnt_dirty_repl,
    output logic [CNT_W-1:0] cnt_stall
);
    // accumulate all four totals
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_access     <= '0;
            cnt_miss       <= '0;
            cnt_dirty_repl <= '0;
            cnt_stall      <= '0;
        end else begin
            if (ev_access)            cnt_access     <= cnt_access + 1'b1;
            if (ev_miss)              cnt_miss       <= cnt_miss + 1'b1;
            if (ev_dirty)             cnt_dirty_repl <= cnt_dirty_repl + 1'b1;
            if (ev_access && ev_read) cnt_stall      <= cnt_stall + CNT_W'(STALL_RD);
        end
    end

    // R8: every miss belongs to an accepted access
    p_miss_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_miss <= cnt_access);
    // R8: every dirty replacement belongs to a miss
    p_dirty_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_dirty_repl <= cnt_miss);
    // R9: a write access leaves the stall total unchanged
    p_write_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_access && !ev_read) |=> $stable(cnt_stall));
endmodule

// File: rtl/wbl2_cache.sv
// Unified second-level cache: set-associative, LRU, write-back, write-allocate.
// Assumes LINE_WORDS >= UP_WORDS >= 1, both powers of two, SETS >= 2, and
// requesters that hold req until ack. One transaction runs at a time.
// A miss writes back a dirty victim, fills the line and re-runs the lookup,
// which then hits and applies the write or returns the read block.
module wbl2_cache
    import l2c_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int UP_WORDS   = 2,
    parameter int SETS       = 4,
    parameter int WAYS       = 2,
    parameter int LOOKUP_CYC = 3,
    parameter int XFER_CYC   = 2,
    parameter int CNT_W      = 32,
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam int IDX_W     = $clog2(SETS),
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int LINE_A_W  = ADDR_W - OFF_W,
    localparam int LINE_BITS = LINE_WORDS * WORD_W,
    localparam int UP_BITS   = UP_WORDS * WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 i_req,
    input  logic [ADDR_W-1:0]    i_addr,
    output logic                 i_ack,
    input  logic                 d_req,
    input  logic                 d_we,
    input  logic [ADDR_W-1:0]    d_addr,
    input  logic [WORD_W-1:0]    d_wdata,
    output logic                 d_ack,
    output logic [UP_BITS-1:0]   up_rdata,
    output logic                 mem_rd_req,
    output logic [LINE_A_W-1:0]  mem_rd_addr,
    input  logic                 mem_rd_valid,
    input  logic [LINE_BITS-1:0] mem_rd_data,
    output logic                 mem_wr_req,
    output logic [LINE_A_W-1:0]  mem_wr_addr,
    output logic [LINE_BITS-1:0] mem_wr_data,
    input  logic                 mem_wr_ack,
    input  logic [ADDR_W-1:0]    prb_addr,
    output logic                 prb_hit,
    output logic [IDX_W-1:0]     prb_set,
    output logic [WAY_W-1:0]     prb_way,
    output logic                 prb_dirty,
    output logic [LINE_BITS-1:0] prb_line,
    output logic [CNT_W-1:0]     cnt_access,
    output logic [CNT_W-1:0]     cnt_miss,
    output logic [CNT_W-1:0]     cnt_dirty_repl,
    output logic [CNT_W-1:0]     cnt_stall
);
    localparam int STALL_RD = LOOKUP_CYC + XFER_CYC * UP_WORDS;

    // line storage
    logic [LINE_BITS-1:0] data_q  [SETS][WAYS];
    logic [TAG_W-1:0]     tag_q   [SETS][WAYS];
    logic                 valid_q [SETS][WAYS];
    logic                 dirty_q [SETS][WAYS];

    // current transaction
    l2c_state_e          state;
    logic                cur_d, cur_we;
    logic [ADDR_W-1:0]   cur_addr;
    logic [WORD_W-1:0]   cur_wdata;
    logic [WAY_W-1:0]    vict_q;
    logic [UP_BITS-1:0]  up_rdata_q;

    logic [IDX_W-1:0]    cur_set;
    logic [TAG_W-1:0]    cur_tag;
    logic [OFF_W-1:0]    cur_off, sub_base;
    logic                hit, has_inv, vdirty, gnt_i, gnt_d;
    logic [WAY_W-1:0]    hit_way, inv_way, lru_way, victim;
    logic                do_fill, do_wr_hit, lookup_miss;
    logic [LINE_BITS-1:0] hit_line;

    assign cur_set  = cur_addr[OFF_W +: IDX_W];
    assign cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
    assign cur_off  = cur_addr[OFF_W-1:0];
    assign sub_base = cur_off & ~OFF_W'(UP_WORDS - 1);

    // tag match for the active request
    always_comb begin
        hit = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (valid_q[cur_set][w] && tag_q[cur_set][w] == cur_tag) begin
                hit = 1'b1;
                hit_way = WAY_W'(w);
            end
    end

    // victim choice: lowest invalid way, otherwise the LRU way
    always_comb begin
        has_inv = 1'b0;
        inv_way = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (!valid_q[cur_set][w]) begin
                has_inv = 1'b1;
                inv_way = WAY_W'(w);
            end
        victim = has_inv ? inv_way : lru_way;
        vdirty = valid_q[cur_set][victim] & dirty_q[cur_set][victim];
    end

    assign hit_line    = data_q[cur_set][hit_way];
    assign do_fill     = (state == ST_FILL) && mem_rd_valid;
    assign do_wr_hit   = (state == ST_LOOKUP) && hit && cur_we;
    assign lookup_miss = (state == ST_LOOKUP) && !hit;

    l2c_arb u_arb (
        .i_req (i_req),
        .d_req (d_req),
        .idle  (state == ST_IDLE),
        .gnt_i (gnt_i),
        .gnt_d (gnt_d)
    );

    l2c_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     ((state == ST_LOOKUP) && hit),
        .touch_set (cur_set),
        .touch_way (hit_way),
        .qry_set   (cur_set),
        .lru_way   (lru_way)
    );

    l2c_stats #(.CNT_W(CNT_W), .STALL_RD(STALL_RD)) u_stats (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_access      (gnt_i | gnt_d),
        .ev_read        (gnt_i | (gnt_d & ~d_we)),
        .ev_miss        (lookup_miss),
        .ev_dirty       (lookup_miss & vdirty),
        .cnt_access     (cnt_access),
        .cnt_miss       (cnt_miss),
        .cnt_dirty_repl (cnt_dirty_repl),
        .cnt_stall      (cnt_stall)
    );

    // transaction sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur_d      <= 1'b0;
            cur_we     <= 1'b0;
            cur_addr   <= '0;
            cur_wdata  <= '0;
            vict_q     <= '0;
            up_rdata_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (gnt_d || gnt_i) begin
                    cur_d     <= gnt_d;
                    cur_we    <= gnt_d & d_we;
                    cur_addr  <= gnt_d ? d_addr : i_addr;
                    cur_wdata <= d_wdata;
                    state     <= ST_LOOKUP;
                end
                ST_LOOKUP: if (hit) begin
                    up_rdata_q <= hit_line[int'(sub_base) * WORD_W +: UP_BITS];
                    state      <= ST_DONE;
                end else begin
                    vict_q <= victim;
                    state  <= vdirty ? ST_WB : ST_FILL;
                end
                ST_WB:   if (mem_wr_ack) state <= ST_FILL;
                ST_FILL: if (mem_rd_valid) state <= ST_LOOKUP;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // valid and dirty state per line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    dirty_q[s][w] <= 1'b0;
                end
        end else begin
            if (do_fill) begin
                valid_q[cur_set][vict_q] <= 1'b1;
                dirty_q[cur_set][vict_q] <= 1'b0;
            end
            if (do_wr_hit) dirty_q[cur_set][hit_way] <= 1'b1;
        end
    end

    // line data and tags: fill and word merge
    always_ff @(posedge clk) begin
        if (do_fill) begin
            data_q[cur_set][vict_q] <= mem_rd_data;
            tag_q[cur_set][vict_q]  <= cur_tag;
        end
        if (do_wr_hit)
            data_q[cur_set][hit_way][int'(cur_off) * WORD_W +: WORD_W] <= cur_wdata;
    end

    // upstream and memory-side outputs
    assign i_ack       = (state == ST_DONE) && !cur_d;
    assign d_ack       = (state == ST_DONE) && cur_d;
    assign up_rdata    = up_rdata_q;
    assign mem_rd_req  = (state == ST_FILL);
    assign mem_rd_addr = {cur_tag, cur_set};
    assign mem_wr_req  = (state == ST_WB);
    assign mem_wr_addr = {tag_q[cur_set][vict_q], cur_set};
    assign mem_wr_data = data_q[cur_set][vict_q];

    // side-effect-free probe lookup
    always_comb begin
        prb_set   = prb_addr[OFF_W +: IDX_W];
        prb_hit   = 1'b0;
        prb_way   = '0;
        for (int w = 0; w < WAYS; w++)
            if (valid_q[prb_set][w] && tag_q[prb_set][w] == prb_addr[ADDR_W-1 -: TAG_W]) begin
                prb_hit = 1'b1;
                prb_way = WAY_W'(w);
            end
        prb_dirty = prb_hit & dirty_q[prb_set][prb_way];
        prb_line  = prb_hit ? data_q[prb_set][prb_way] : '0;
    end

    // R10: acknowledges never overlap
    p_ack_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(i_ack && d_ack));
    // R10: a tie in idle starts the data-side transaction
    p_data_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && i_req && d_req) |=> (state == ST_LOOKUP && cur_d));
    // R12: at most one memory request at a time
    p_one_mem_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));
    // R12: an unanswered read stays asserted at the same address
    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
    // R12: an unanswered write stays asserted with the same address and data
    p_wr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=>
        (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));
    // R7: an accepted write-back is followed directly by the fill read
    p_wb_to_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && mem_wr_ack) |=> mem_rd_req);
endmodule

// File: tb/wbl2_cache_tb_top.sv
`timescale 1ns/1ps
module wbl2_cache_tb_top;
    localparam int AW = 12, LW = 4, UW = 2, NS = 4, NW = 2, STALL = 3 + 2 * UW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic i_req = 0, d_req = 0, d_we = 0;
    logic [AW-1:0] i_addr = '0, d_addr = '0, prb_addr = '0;
    logic [31:0] d_wdata = '0;
    logic i_ack, d_ack, mem_rd_req, mem_wr_req, prb_hit, prb_dirty;
    logic mem_rd_valid = 0, mem_wr_ack = 0;
    logic [63:0] up_rdata;
    logic [127:0] mem_rd_data = '0, mem_wr_data, prb_line;
    logic [9:0] mem_rd_addr, mem_wr_addr;
    logic [1:0] prb_set;
    logic [0:0] prb_way;
    logic [31:0] cnt_access, cnt_miss, cnt_dirty_repl, cnt_stall;

    always #2 clk = ~clk;

    wbl2_cache dut_i (
        .clk(clk), .rst_n(rst_n), .i_req(i_req), .i_addr(i_addr), .i_ack(i_ack),
        .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata), .d_ack(d_ack),
        .up_rdata(up_rdata), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
        .prb_addr(prb_addr), .prb_hit(prb_hit), .prb_set(prb_set), .prb_way(prb_way),
        .prb_dirty(prb_dirty), .prb_line(prb_line), .cnt_access(cnt_access),
        .cnt_miss(cnt_miss), .cnt_dirty_repl(cnt_dirty_repl), .cnt_stall(cnt_stall)
    );

    int n_chk = 0, n_err = 0;
    bit in_txn = 0;
    logic [31:0] phys_mem [4096];
    logic [31:0] ref_mem  [4096];
    // behavioural cache model
    bit          m_valid [NS][NW];
    bit          m_dirty [NS][NW];
    int          m_tag   [NS][NW];
    int          m_stamp [NS][NW];
    logic [31:0] m_data  [NS][NW][LW];
    int stamp_ctr = 0;
    int e_acc = 0, e_miss = 0, e_dirty = 0, e_stall = 0;
    // memory responder observations
    int rd_cnt = 0, wr_cnt = 0, rd_wait = 0, wr_wait = 0;
    bit rd_seen = 0, order_bad = 0;
    logic [9:0] wb_addr_seen;
    logic [127:0] wb_data_seen;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory: answers reads and write-backs after a few cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_valid) mem_rd_valid = 0;
            else if (mem_rd_req) begin
                rd_seen = 1;
                rd_wait++;
                if (rd_wait == 3) begin
                    rd_wait = 0;
                    rd_cnt++;
                    for (int k = 0; k < LW; k++)
                        mem_rd_data[32*k +: 32] = phys_mem[{mem_rd_addr, 2'(k)}];
                    mem_rd_valid = 1;
                end
            end
            if (mem_wr_ack) mem_wr_ack = 0;
            else if (mem_wr_req) begin
                wr_wait++;
                if (wr_wait == 2) begin
                    wr_wait = 0;
                    wr_cnt++;
                    if (rd_seen) order_bad = 1;
                    wb_addr_seen = mem_wr_addr;
                    wb_data_seen = mem_wr_data;
                    for (int k = 0; k < LW; k++)
                        phys_mem[{mem_wr_addr, 2'(k)}] = mem_wr_data[32*k +: 32];
                    mem_wr_ack = 1;
                end
            end
        end
    end

    // model lookup: returns way or -1
    function automatic int m_find(input int addr);
        int s = (addr >> 2) & 3;
        int t = addr >> 4;
        for (int w = 0; w < NW; w++)
            if (m_valid[s][w] && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    task automatic model_txn(input bit we, input int addr, input logic [31:0] wd,
                             output logic [63:0] rd, output bit miss, output bit wb,
                             output int wb_line, output logic [127:0] wb_data);
        int s = (addr >> 2) & 3, t = addr >> 4, off = addr & 3, w;
        e_acc++;
        if (!we) e_stall += STALL;
        wb = 0; wb_line = 0; wb_data = '0;
        w = m_find(addr);
        miss = (w < 0);
        if (miss) begin
            e_miss++;
            w = -1;
            for (int k = 0; k < NW; k++) if (w < 0 && !m_valid[s][k]) w = k;
            if (w < 0) begin
                w = 0;
                for (int k = 1; k < NW; k++) if (m_stamp[s][k] < m_stamp[s][w]) w = k;
            end
            if (m_valid[s][w] && m_dirty[s][w]) begin
                e_dirty++;
                wb = 1;
                wb_line = (m_tag[s][w] << 2) | s;
                for (int k = 0; k < LW; k++) begin
                    wb_data[32*k +: 32] = m_data[s][w][k];
                    ref_mem[wb_line * LW + k] = m_data[s][w][k];
                end
            end
            for (int k = 0; k < LW; k++) m_data[s][w][k] = ref_mem[((t << 2) | s) * LW + k];
            m_valid[s][w] = 1; m_dirty[s][w] = 0; m_tag[s][w] = t;
        end
        m_stamp[s][w] = ++stamp_ctr;
        if (we) begin
            m_data[s][w][off] = wd;
            m_dirty[s][w] = 1;
        end
        rd = {m_data[s][w][(off & ~1) + 1], m_data[s][w][off & ~1]};
    endtask

    // one request, checked against the model; starts and ends on a falling edge
    task automatic run_txn(input bit is_d, input bit we, input int addr, input logic [31:0] wd);
        logic [63:0] got, exp;
        bit miss, wb;
        int wb_line;
        logic [127:0] wb_data;
        rd_cnt = 0; wr_cnt = 0; rd_seen = 0; order_bad = 0;
        in_txn = 1;
        if (is_d) begin d_req = 1; d_we = we; d_addr = AW'(addr); d_wdata = wd; end
        else begin i_req = 1; i_addr = AW'(addr); end
        do @(negedge clk); while (!(is_d ? d_ack : i_ack));
        got = up_rdata;
        d_req = 0; i_req = 0;
        model_txn(we, addr, wd, exp, miss, wb, wb_line, wb_data);
        if (!we) chk(got == exp, "R2 read block data", got, exp);
        if (miss) chk(rd_cnt == 1, we ? "R4 allocate fill count" : "R5 read fill count", rd_cnt, 1);
        else chk(rd_cnt == 0 && wr_cnt == 0, we ? "R3 write hit memory traffic" : "R2 read hit memory traffic",
                 rd_cnt + wr_cnt, 0);
        chk(wr_cnt == int'(wb), "R7 write-back count", wr_cnt, wb);
        if (wb) begin
            chk(wb_addr_seen == 10'(wb_line), "R7 write-back line address", wb_addr_seen, wb_line);
            chk(wb_data_seen == wb_data, "R7 write-back line data", wb_data_seen, wb_data);
            chk(!order_bad, "R7 write-back before fill", order_bad, 0);
        end
        in_txn = 0;
        @(negedge clk);
    endtask

    task automatic probe_chk(input int addr);
        int w, s;
        logic [127:0] line;
        prb_addr = AW'(addr);
        #1;
        w = m_find(addr);
        s = (addr >> 2) & 3;
        chk(prb_hit == (w >= 0), "R11 probe hit", prb_hit, w >= 0);
        chk(prb_set == 2'(s), "R11 probe set", prb_set, s);
        if (w >= 0) begin
            for (int k = 0; k < LW; k++) line[32*k +: 32] = m_data[s][w][k];
            chk(prb_way == 1'(w), "R11 probe way", prb_way, w);
            chk(prb_dirty == m_dirty[s][w], "R11 probe dirty", prb_dirty, m_dirty[s][w]);
            chk(prb_line == line, "R11 probe line", prb_line, line);
        end
    endtask

    // per-clock comparison of the counters with the model while idle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && !in_txn) begin
                chk(cnt_access == 32'(e_acc), "R8 access count", cnt_access, e_acc);
                chk(cnt_miss == 32'(e_miss), "R8 miss count", cnt_miss, e_miss);
                chk(cnt_dirty_repl == 32'(e_dirty), "R8 dirty replacement count", cnt_dirty_repl, e_dirty);
                chk(cnt_stall == 32'(e_stall), "R9 stall count", cnt_stall, e_stall);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] st0;
        logic [63:0] got, exp;
        bit miss, wb;
        int wbl;
        logic [127:0] wbd;
        for (int i = 0; i < 4096; i++) begin
            phys_mem[i] = 32'(i) * 32'h9E3779B1 ^ 32'h5A000000;
            ref_mem[i]  = phys_mem[i];
        end
        in_txn = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(!i_ack && !d_ack && !mem_rd_req && !mem_wr_req, "R1 idle outputs after reset",
            {i_ack, d_ack, mem_rd_req, mem_wr_req}, 0);
        chk(cnt_access == 0 && cnt_miss == 0 && cnt_dirty_repl == 0 && cnt_stall == 0,
            "R1 counters after reset", cnt_access | cnt_miss | cnt_dirty_repl | cnt_stall, 0);
        prb_addr = 12'h010; #1;
        chk(!prb_hit, "R1 probe misses after reset", prb_hit, 0);
        in_txn = 0;
        @(negedge clk);

        // R5 read miss into set 1, then R2 hit on the other sub-block
        st0 = cnt_stall;
        run_txn(1, 0, 12'h005, '0);
        chk(cnt_stall == st0 + STALL, "R9 read adds stall", cnt_stall, st0 + STALL);
        run_txn(0, 0, 12'h006, '0);
        probe_chk(12'h005);
        // R3 write hit
        st0 = cnt_stall;
        run_txn(1, 1, 12'h007, 32'hCAFE0007);
        chk(cnt_stall == st0, "R9 write adds no stall", cnt_stall, st0);
        probe_chk(12'h004);
        // R4 write miss allocates into way 1 of set 1 (R6 invalid way first)
        run_txn(1, 1, 12'h016, 32'hBEEF0016);
        probe_chk(12'h014);
        chk(prb_way == 1'b1, "R6 fill uses free way", prb_way, 1);
        // R7 third tag in set 1: victim is LRU way 0, which is dirty
        run_txn(0, 0, 12'h025, '0);
        probe_chk(12'h025);
        chk(prb_way == 1'b0, "R6 LRU way replaced", prb_way, 0);
        run_txn(1, 0, 12'h007, '0);
        probe_chk(12'h007);
        probe_chk(12'h3F0);

        // R10 simultaneous requests: data first, instruction held
        in_txn = 1;
        d_req = 1; d_we = 0; d_addr = 12'h031; i_req = 1; i_addr = 12'h042;
        do @(negedge clk); while (!d_ack && !i_ack);
        chk(d_ack && !i_ack, "R10 data side served first", {d_ack, i_ack}, 2'b10);
        got = up_rdata; d_req = 0;
        model_txn(0, 12'h031, '0, exp, miss, wb, wbl, wbd);
        chk(got == exp, "R10 data-side block", got, exp);
        do @(negedge clk); while (!i_ack);
        got = up_rdata; i_req = 0;
        model_txn(0, 12'h042, '0, exp, miss, wb, wbl, wbd);
        chk(got == exp, "R10 held instruction request served", got, exp);
        in_txn = 0;
        @(negedge clk);

        // mixed traffic over a small window to force conflicts and dirty evictions
        for (int n = 0; n < 400; n++) begin
            bit isd, we;
            isd = 1'($urandom);
            we  = isd & 1'($urandom);
            run_txn(isd, we, int'($urandom % 96), $urandom);
            if (n % 25 == 0) probe_chk(int'($urandom % 96));
        end
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule